// File: doc/BRIEF.md
# Multi-Channel ADC Scan Sequencer

This block drives a successive-approximation converter that sits behind an eight-way analog input multiplexer. It steps through the channels that software has enabled, from the lowest number upward. For each channel it selects the mux input, holds the sample-and-hold in acquisition for that channel's own programmed time, and then issues a one-cycle convert request. When the converter reports a result, the block stores it in that channel's private result register and marks it valid. Software can therefore read a whole scan at once, without servicing every conversion.

Every stored result can be compared with a shared pair of low and high limits. If range checking is on for that channel and the result falls outside the limits, a sticky per-channel flag is set on the same edge that stores the result. The range interrupt follows in the next cycle, while the scan is still running. An end-of-scan flag marks the completion of each pass. In continuous mode the scan then wraps to the lowest enabled channel with no idle cycle. A manual mode converts one channel that software selects, once per command.

The block is configured and read through a simple synchronous register port with combinational read data. Reading a channel's result register clears that channel's valid bit.

Top module: `adc_scan_seq`

## Requirements
- R1: In scan mode a pass visits only the channels whose bit is set in CHEN[7:0] (address 0x02), in ascending channel order, and drives each channel's number on `mux_sel` while that channel is being sampled and converted.
- R2: When a conversion result arrives (`adc_done` high) and another channel follows in the same scan, or the scan wraps in continuous mode, `adc_sample` is high in the very next cycle with the new channel on `mux_sel`. No idle cycle is inserted.
- R3: For channel c, `adc_sample` stays high for exactly STIME_c+1 consecutive cycles, where STIME_c is bits [7:0] at address 0x08+c. `adc_start` is high only in the last of those cycles, and `mux_sel` is stable throughout.
- R4: A result taken while channel c is converting is stored in RESULT_c (address 0x10+c, data in [11:0]), and its valid bit [31] is set.
- R5: A register read of RESULT_c clears that channel's valid bit. The data remains readable.
- R6: When CHEN[8+c] (range enable) is set, a result strictly below LIMIT[11:0] or strictly above LIMIT[27:16] (address 0x03) sets flag c in STATUS[7:0] (address 0x04). A result equal to a limit, or on a channel whose range check is off, sets no flag. `irq_range` is the OR of the flags and goes high in the cycle after `adc_done`, before the scan ends.
- R7: Writing ones to STATUS[7:0] clears those flags. Writing a one to STATUS[8] clears the end-of-scan flag. Bits written with zero are left unchanged.
- R8: After the last enabled channel of a pass, the end-of-scan flag STATUS[8] and `irq_eos` are set. When CTRL[0] (continuous, address 0x00) is clear, the block then returns to idle, and STATUS[24] (busy) reads 0.
- R9: With CTRL[0] set, the scan wraps to the lowest enabled channel after each pass. Clearing CTRL[0] lets the current pass finish and then stop.
- R10: With CTRL[1] set (manual), a start command converts only the channel in CTRL[4:2], once. It then returns to idle without setting the end-of-scan flag.
- R11: A start command (writing 1 to bit 0 of address 0x01) in scan mode with no channel enabled is ignored, and no sampling begins.
- R12: After reset the block is idle: `adc_sample`, `adc_start`, `irq_range` and `irq_eos` are low, and STATUS reads zero, which includes all valid bits being clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives read side effects) |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| mux_sel | output | 3 | Analog mux channel select |
| adc_sample | output | 1 | Sample-and-hold acquiring |
| adc_start | output | 1 | One-cycle convert request |
| adc_done | input | 1 | Converter result valid pulse |
| adc_result | input | 12 | Converter result |
| irq_range | output | 1 | Out-of-range interrupt (OR of sticky flags) |
| irq_eos | output | 1 | End-of-scan interrupt |

## Verification
A wrong channel pointer appears at the first `adc_start` of a pass as the wrong `mux_sel`. A miscounted acquisition counter appears as an `adc_sample` run of the wrong length before the same strobe. A lost hand-off between channels appears as a low `adc_sample` one cycle after `adc_done`. A flawed range comparison or flag register shows on `irq_range` in the cycle after the offending result, which is well before `irq_eos`. A defect in storage or in valid clearing shows only on the next register read of that channel, so the bench reads each converted channel twice.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int CH_N   = 8;
    localparam int CH_W   = $clog2(CH_N);
    localparam int DATA_W = 12;
    localparam int ST_W   = 8;
    localparam int ADDR_W = 5;
    localparam int REG_W  = 32;
    localparam int PG_W   = ADDR_W - CH_W;

    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_CHEN  = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_LIMIT = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(4);
    localparam logic [PG_W-1:0]   PG_STIME = PG_W'(1);
    localparam logic [PG_W-1:0]   PG_RES   = PG_W'(2);

    typedef enum logic [1:0] {SQ_IDLE, SQ_ACQ, SQ_CONV} sq_state_e;

    typedef struct packed {
        logic              hit;
        logic [CH_W-1:0]   ch;
        logic [DATA_W-1:0] data;
    } conv_evt_t;

    typedef struct packed {
        logic            found;
        logic [CH_W-1:0] ch;
    } ch_pick_t;

    // lowest set bit of the mask
    function automatic ch_pick_t first_set(input logic [CH_N-1:0] m);
        ch_pick_t r;
        r = '0;
        for (int i = CH_N - 1; i >= 0; i--) begin
            if (m[i]) begin
                r.found = 1'b1;
                r.ch    = CH_W'(i);
            end
        end
        return r;
    endfunction

    // lowest set bit strictly above the current channel
    function automatic ch_pick_t next_above(input logic [CH_N-1:0] m,
                                            input logic [CH_W-1:0] cur);
        ch_pick_t r;
        r = '0;
        for (int i = CH_N - 1; i >= 0; i--) begin
            if (m[i] && (i > int'(cur))) begin
                r.found = 1'b1;
                r.ch    = CH_W'(i);
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start_i,
    input  logic                      cont_i,
    input  logic                      manual_i,
    input  logic [CH_W-1:0]           man_ch_i,
    input  logic [CH_N-1:0]           chen_i,
    input  logic [CH_N-1:0][ST_W-1:0] stime_i,
    input  logic                      adc_done_i,
    input  logic [DATA_W-1:0]         adc_result_i,
    output logic [CH_W-1:0]           mux_sel_o,
    output logic                      adc_sample_o,
    output logic                      adc_start_o,
    output logic                      busy_o,
    output conv_evt_t                 evt_o,
    output logic                      eos_o
);
    sq_state_e       state_q;
    logic [CH_W-1:0] cur_q;
    logic [ST_W-1:0] cnt_q;
    logic            man_q;
    ch_pick_t        pick, wrap;

    always_comb begin
        pick       = next_above(chen_i, cur_q);
        wrap       = first_set(chen_i);
        evt_o.hit  = (state_q == SQ_CONV) && adc_done_i;
        evt_o.ch   = cur_q;
        evt_o.data = adc_result_i;
        eos_o      = evt_o.hit && !man_q && !pick.found;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            cur_q   <= '0;
            cnt_q   <= '0;
            man_q   <= 1'b0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (start_i) begin
                        if (manual_i) begin
                            cur_q   <= man_ch_i;
                            cnt_q   <= stime_i[man_ch_i];
                            man_q   <= 1'b1;
                            state_q <= SQ_ACQ;
                        end else if (wrap.found) begin
                            cur_q   <= wrap.ch;
                            cnt_q   <= stime_i[wrap.ch];
                            man_q   <= 1'b0;
                            state_q <= SQ_ACQ;
                        end
                    end
                end
                SQ_ACQ: begin
                    if (cnt_q == '0) state_q <= SQ_CONV;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                SQ_CONV: begin
                    if (adc_done_i) begin
                        if (man_q) begin
                            state_q <= SQ_IDLE;
                        end else if (pick.found) begin
                            cur_q   <= pick.ch;
                            cnt_q   <= stime_i[pick.ch];
                            state_q <= SQ_ACQ;
                        end else if (cont_i && wrap.found) begin
                            cur_q   <= wrap.ch;
                            cnt_q   <= stime_i[wrap.ch];
                            state_q <= SQ_ACQ;
                        end else begin
                            state_q <= SQ_IDLE;
                        end
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign mux_sel_o    = cur_q;
    assign adc_sample_o = (state_q == SQ_ACQ);
    assign adc_start_o  = (state_q == SQ_ACQ) && (cnt_q == '0);
    assign busy_o       = (state_q != SQ_IDLE);

    // R3
    acq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (adc_sample_o && !adc_start_o) |=> (adc_sample_o && $stable(mux_sel_o)));
    // R3
    start_end_chk: assert property (@(posedge clk) disable iff (rst)
        adc_start_o |=> (!adc_sample_o && busy_o));
    // R2
    no_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_o.hit && !eos_o && !man_q) |=> adc_sample_o);
    // R10
    man_single_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_o.hit && man_q) |=> !busy_o);
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
    import adc_seq_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  conv_evt_t                   evt_i,
    input  logic [CH_N-1:0]             rd_clr_i,
    output logic [CH_N-1:0][DATA_W-1:0] data_o,
    output logic [CH_N-1:0]             valid_o
);
    for (genvar g = 0; g < CH_N; g++) begin : g_slot
        logic store;
        assign store = evt_i.hit && (evt_i.ch == CH_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                data_o[g]  <= '0;
                valid_o[g] <= 1'b0;
            end else if (store) begin
                data_o[g]  <= evt_i.data;
                valid_o[g] <= 1'b1;
            end else if (rd_clr_i[g]) begin
                valid_o[g] <= 1'b0;
            end
        end

        // R5
        rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (rd_clr_i[g] && !store) |=> !valid_o[g]);
    end

    // R4
    store_chk: assert property (@(posedge clk) disable iff (rst)
        evt_i.hit |=> (valid_o[$past(evt_i.ch)] &&
                       data_o[$past(evt_i.ch)] == $past(evt_i.data)));
endmodule

// File: rtl/adc_range_check.sv
module adc_range_check
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  conv_evt_t         evt_i,
    input  logic [CH_N-1:0]   rchk_en_i,
    input  logic [DATA_W-1:0] lo_i,
    input  logic [DATA_W-1:0] hi_i,
    input  logic [CH_N-1:0]   clr_i,
    output logic [CH_N-1:0]   flags_o
);
    logic            outside;
    logic [CH_N-1:0] set_vec;

    always_comb begin
        outside = (evt_i.data < lo_i) || (evt_i.data > hi_i);
        set_vec = '0;
        if (evt_i.hit && rchk_en_i[evt_i.ch] && outside)
            set_vec[evt_i.ch] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_o <= '0;
        else     flags_o <= (flags_o & ~clr_i) | set_vec;
    end

    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_i.hit && rchk_en_i[evt_i.ch] && (evt_i.data > hi_i)) |=> flags_o[$past(evt_i.ch)]);
    // R7
    flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (!evt_i.hit && (clr_i != '0)) |=> ((flags_o & $past(clr_i)) == '0));
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic [CH_W-1:0]   mux_sel,
    output logic              adc_sample,
    output logic              adc_start,
    input  logic              adc_done,
    input  logic [DATA_W-1:0] adc_result,
    output logic              irq_range,
    output logic              irq_eos
);
    logic                        cont_q, man_q;
    logic [CH_W-1:0]             mch_q;
    logic [CH_N-1:0]             chen_q, rchk_q;
    logic [DATA_W-1:0]           lo_q, hi_q;
    logic [CH_N-1:0][ST_W-1:0]   stime_q;
    logic                        eos_q;

    logic [PG_W-1:0]             page;
    logic [CH_W-1:0]             idx;
    logic                        start, busy, eos_pulse;
    logic [CH_N-1:0]             clr_mask, rd_clr, flags, res_valid;
    logic [CH_N-1:0][DATA_W-1:0] res_data;
    conv_evt_t                   evt;

    assign page     = reg_addr[ADDR_W-1:CH_W];
    assign idx      = reg_addr[CH_W-1:0];
    assign start    = reg_wr && (reg_addr == A_CMD) && reg_wdata[0];
    assign clr_mask = (reg_wr && reg_addr == A_STAT) ? reg_wdata[CH_N-1:0] : '0;

    for (genvar g = 0; g < CH_N; g++) begin : g_rdclr
        assign rd_clr[g] = reg_rd && (page == PG_RES) && (idx == CH_W'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cont_q  <= 1'b0;
            man_q   <= 1'b0;
            mch_q   <= '0;
            chen_q  <= '0;
            rchk_q  <= '0;
            lo_q    <= '0;
            hi_q    <= '1;
            stime_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == A_CTRL) begin
                cont_q <= reg_wdata[0];
                man_q  <= reg_wdata[1];
                mch_q  <= reg_wdata[2 +: CH_W];
            end
            if (reg_addr == A_CHEN) begin
                chen_q <= reg_wdata[0 +: CH_N];
                rchk_q <= reg_wdata[CH_N +: CH_N];
            end
            if (reg_addr == A_LIMIT) begin
                lo_q <= reg_wdata[0 +: DATA_W];
                hi_q <= reg_wdata[16 +: DATA_W];
            end
            if (page == PG_STIME) stime_q[idx] <= reg_wdata[ST_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                                            eos_q <= 1'b0;
        else if (eos_pulse)                                 eos_q <= 1'b1;
        else if (reg_wr && reg_addr == A_STAT && reg_wdata[8]) eos_q <= 1'b0;
    end

    adc_seq_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start_i(start), .cont_i(cont_q),
        .manual_i(man_q), .man_ch_i(mch_q), .chen_i(chen_q),
        .stime_i(stime_q), .adc_done_i(adc_done), .adc_result_i(adc_result),
        .mux_sel_o(mux_sel), .adc_sample_o(adc_sample), .adc_start_o(adc_start),
        .busy_o(busy), .evt_o(evt), .eos_o(eos_pulse)
    );

    adc_result_bank u_bank (
        .clk(clk), .rst(rst), .evt_i(evt), .rd_clr_i(rd_clr),
        .data_o(res_data), .valid_o(res_valid)
    );

    adc_range_check u_range (
        .clk(clk), .rst(rst), .evt_i(evt), .rchk_en_i(rchk_q),
        .lo_i(lo_q), .hi_i(hi_q), .clr_i(clr_mask), .flags_o(flags)
    );

    always_comb begin
        reg_rdata = '0;
        if (page == PG_STIME) begin
            reg_rdata[ST_W-1:0] = stime_q[idx];
        end else if (page == PG_RES) begin
            reg_rdata[DATA_W-1:0] = res_data[idx];
            reg_rdata[REG_W-1]    = res_valid[idx];
        end else begin
            case (reg_addr)
                A_CTRL: begin
                    reg_rdata[0]         = cont_q;
                    reg_rdata[1]         = man_q;
                    reg_rdata[2 +: CH_W] = mch_q;
                end
                A_CHEN:  reg_rdata[2*CH_N-1:0] = {rchk_q, chen_q};
                A_LIMIT: begin
                    reg_rdata[0 +: DATA_W]  = lo_q;
                    reg_rdata[16 +: DATA_W] = hi_q;
                end
                A_STAT: begin
                    reg_rdata[CH_N-1:0] = flags;
                    reg_rdata[8]        = eos_q;
                    reg_rdata[16 +: CH_N] = res_valid;
                    reg_rdata[24]       = busy;
                end
                default: reg_rdata = '0;
            endcase
        end
    end

    assign irq_range = |flags;
    assign irq_eos   = eos_q;

    // R8
    eos_irq_chk: assert property (@(posedge clk) disable iff (rst)
        eos_pulse |=> irq_eos);
endmodule

// File: tb/tb_adc_scan_seq.sv
module tb_adc_scan_seq;
    localparam int CLK_PERIOD = 10;
    localparam int CONV_CYC   = 18;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [2:0]  mux_sel;
    logic        adc_sample, adc_start, adc_done, irq_range, irq_eos;
    logic [11:0] adc_result;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;
    int unsigned exp_q[$];
    logic [11:0] ana [8];
    int stime_cfg [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_scan_seq dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mux_sel(mux_sel), .adc_sample(adc_sample), .adc_start(adc_start),
        .adc_done(adc_done), .adc_result(adc_result),
        .irq_range(irq_range), .irq_eos(irq_eos)
    );

    // behavioural converter: a result CONV_CYC cycles after each start
    logic [2:0] ch_l;
    int         cnt_m;
    always @(posedge clk) begin
        if (rst) begin
            adc_done <= 1'b0; adc_result <= '0; cnt_m <= 0; ch_l <= '0;
        end else begin
            adc_done <= 1'b0;
            if (cnt_m != 0) begin
                cnt_m <= cnt_m - 1;
                if (cnt_m == 1) begin
                    adc_done   <= 1'b1;
                    adc_result <= ana[ch_l];
                end
            end else if (adc_start) begin
                ch_l  <= mux_sel;
                cnt_m <= CONV_CYC;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // monitor: pops the expected channel order at each convert strobe
    int  run = 0;
    bit  prev_done = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_done) begin
                if (exp_q.size() > 0) begin
                    chk(adc_sample == 1'b1, "R2 sample right after result", int'(adc_sample), 1);
                    chk(mux_sel == exp_q[0], "R1 next channel on mux", int'(mux_sel), int'(exp_q[0]));
                end else begin
                    chk(adc_sample == 1'b0, "R8 idle after last channel", int'(adc_sample), 0);
                end
            end
            if (adc_sample) run++;
            if (adc_start) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R1 unexpected conversion", int'(mux_sel), -1);
                end else begin
                    chk(mux_sel == exp_q[0], "R1 channel order", int'(mux_sel), int'(exp_q[0]));
                    chk(run == stime_cfg[exp_q[0]] + 1, "R3 sample length", run, stime_cfg[exp_q[0]] + 1);
                    void'(exp_q.pop_front());
                end
            end
            if (!adc_sample) run = 0;
            prev_done = adc_done;
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!adc_done);
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        int guard = 0;
        do begin
            rd(5'h04, s);
            guard++;
        end while (s[24] && guard < 2000);
    endtask

    task automatic set_stime(input int c, input int t);
        stime_cfg[c] = t;
        wr(5'h08 + 5'(c), 32'(t));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 8; i++) begin ana[i] = 12'(i * 10); stime_cfg[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R12 reset state
        rd(5'h04, v);
        chk(v == 32'h0, "R12 status after reset", int'(v), 0);
        chk(!adc_sample && !adc_start && !irq_range && !irq_eos, "R12 outputs idle",
            int'({adc_sample, adc_start, irq_range, irq_eos}), 0);

        // scan 1: channels 0,2,5,7 with range checks on 2,5,7
        set_stime(0, 3); set_stime(2, 0); set_stime(5, 7); set_stime(7, 2);
        ana[0] = 12'd4000; ana[2] = 12'd50; ana[5] = 12'd3500; ana[7] = 12'd100;
        wr(5'h03, {4'h0, 12'd3000, 4'h0, 12'd100});
        wr(5'h02, 32'h0000_A4A5);
        wr(5'h00, 32'h0);
        exp_q.push_back(0); exp_q.push_back(2); exp_q.push_back(5); exp_q.push_back(7);
        wr(5'h01, 32'h1);
        wait_done();
        @(negedge clk);
        // R6 range check disabled on channel 0
        chk(irq_range == 1'b0, "R6 no flag with check off", int'(irq_range), 0);
        wait_done();
        @(negedge clk);
        // R6 early interrupt, before the scan ends
        chk(irq_range == 1'b1, "R6 irq after low result", int'(irq_range), 1);
        chk(irq_eos == 1'b0, "R6 irq before end of scan", int'(irq_eos), 0);
        wait_idle();
        chk(exp_q.size() == 0, "R1 all channels visited", exp_q.size(), 0);
        rd(5'h04, v);
        chk(v[7:0] == 8'h24, "R6 flags strict compare", int'(v[7:0]), 'h24);
        chk(v[8] == 1'b1 && irq_eos, "R8 end-of-scan flag", int'(v[8]), 1);
        chk(v[23:16] == 8'hA5, "R4 valid bits", int'(v[23:16]), 'hA5);
        rd(5'h10, v);
        chk(v == 32'h8000_0FA0, "R4 result ch0", int'(v), 'h80000FA0);
        rd(5'h10, v);
        chk(v == 32'h0000_0FA0, "R5 valid cleared by read", int'(v), 'hFA0);
        rd(5'h12, v);
        chk(v == 32'h8000_0032, "R4 result ch2", int'(v), 'h80000032);
        rd(5'h15, v);
        chk(v == 32'h8000_0DAC, "R4 result ch5", int'(v), 'h80000DAC);
        rd(5'h17, v);
        chk(v == 32'h8000_0064, "R4 result ch7", int'(v), 'h80000064);
        rd(5'h11, v);
        chk(v[31] == 1'b0, "R4 unconverted channel not valid", int'(v[31]), 0);

        // R7 partial then full clear
        wr(5'h04, 32'h0000_0004);
        rd(5'h04, v);
        chk(v[8:0] == 9'h120 && irq_range, "R7 partial W1C", int'(v[8:0]), 'h120);
        wr(5'h04, 32'h0000_0120);
        rd(5'h04, v);
        chk(v[8:0] == 9'h000 && !irq_range && !irq_eos, "R7 full W1C", int'(v[8:0]), 0);

        // R11 start with nothing enabled
        wr(5'h02, 32'h0);
        wr(5'h01, 32'h1);
        chk(adc_sample == 1'b0, "R11 no sampling", int'(adc_sample), 0);
        rd(5'h04, v);
        chk(v[24] == 1'b0, "R11 stays idle", int'(v[24]), 0);

        // R9 continuous wrap over channels 3 and 6
        set_stime(3, 1); set_stime(6, 4);
        ana[3] = 12'd333; ana[6] = 12'd666;
        wr(5'h02, 32'h0000_0048);
        wr(5'h00, 32'h1);
        for (int k = 0; k < 3; k++) begin exp_q.push_back(3); exp_q.push_back(6); end
        wr(5'h01, 32'h1);
        repeat (4) wait_done();
        wr(5'h00, 32'h0);
        wait_idle();
        chk(exp_q.size() == 0, "R9 wrapped passes then stop", exp_q.size(), 0);
        rd(5'h16, v);
        chk(v == 32'h8000_029A, "R9 result ch6", int'(v), 'h8000029A);
        wr(5'h04, 32'h0000_01FF);

        // R10 manual conversion of channel 4
        set_stime(4, 5);
        ana[4] = 12'd1234;
        wr(5'h00, 32'h0000_0012);
        exp_q.push_back(4);
        wr(5'h01, 32'h1);
        wait_idle();
        chk(exp_q.size() == 0, "R10 single manual conversion", exp_q.size(), 0);
        rd(5'h14, v);
        chk(v == 32'h8000_04D2, "R10 manual result", int'(v), 'h800004D2);
        rd(5'h04, v);
        chk(v[8] == 1'b0 && !irq_eos, "R10 no end-of-scan", int'(v[8]), 0);

        repeat (5) @(negedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule